// File: doc/BRIEF.md
# Programmable Transition-Mapped Event Counter

This block counts events on a group of one to three digital lines. Its behaviour is set entirely by a writable lookup table, with no fixed up, down or quadrature logic. The lines are resynchronised to the local clock. Each time the synchronised line state differs from the state seen one cycle earlier, the pair (earlier state, new state) selects one table entry. That entry tells the counter to step up by one, step down by one, hold, or report an illegal move.

Each entry also carries two more bits. The first asks for the counter value to be copied into a small capture queue, which is read out later at the consumer's own pace. The second asks for a one-cycle interrupt pulse. With these entries one design can act as an edge counter, a direction-gated counter or a quadrature decoder. It can also catch forbidden transitions, such as both quadrature lines changing at once.

A control sequencer starts in ST_SYNC0 after reset. The transition T_FILL1 leads to ST_SYNC1 while the first synchroniser stage loads. T_FILL2 leads to ST_SEED while the second stage loads. T_ARM leads to ST_RUN once the previous-state register holds a valid sample. ST_RUN holds until reset (T_STAY). Table lookups take effect only in ST_RUN.

Top module: `trans_event_counter`

## Requirements
- R1: A change on `din` affects `count` at the third rising clock edge after the change. Two edges go to synchronisation and one to the count register. After only two edges the count still shows the old value.
- R2: Reset clears the following: every table entry to hold, `count` to 0, `err_flag`, `fifo_ovf` and `irq` to 0, and the capture queue to empty (`fifo_empty`=1, `fifo_full`=0). Until the sequencer reaches ST_RUN, `count` does not change.
- R3: Writing the table with `tbl_we`=1 stores `tbl_wdata` at `tbl_addr`. The address is {previous state, new state}, with the previous state in the upper NUM_IN bits. Data bits [1:0] hold the action: 00 hold, 01 increment, 10 decrement, 11 exception. Bit 2 requests a capture and bit 3 requests an interrupt. A rewritten entry governs later transitions.
- R4: The increment and decrement actions change `count` by exactly one, and the count wraps modulo 2^CNT_W. `count` never moves by more than one per cycle.
- R5: When the synchronised state equals the previous state, no entry is applied, and `count`, `err_flag`, `irq` and the queue stay unchanged.
- R6: The exception action sets the sticky flag `err_flag` and leaves `count` unchanged. A `flag_clr` pulse clears the flag. If a new exception arrives in the same cycle as the clear, the flag stays set.
- R7: A capture pushes the count value held before the same transition's action is applied. `fifo_data` shows the oldest entry, and `fifo_rd` removes it. Entries leave the queue in the order they were pushed. A read while the queue is empty has no effect.
- R8: The queue holds FIFO_DEPTH (8) entries. A push into a full queue is dropped and sets the sticky flag `fifo_ovf`, which `flag_clr` clears. `fifo_full` and `fifo_empty` are never high together.
- R9: An entry with the interrupt bit set drives `irq` high for exactly one cycle, in the same cycle that its count action becomes visible.
- R10: The capture, the interrupt and the count action of one entry all take effect on the same transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| din | input | NUM_IN | Asynchronous event lines |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 2*NUM_IN | Table address {previous, new} |
| tbl_wdata | input | 4 | Entry: {irq, capture, action[1:0]} |
| flag_clr | input | 1 | Clears `err_flag` and `fifo_ovf` |
| count | output | CNT_W | Current count |
| err_flag | output | 1 | Sticky exception flag |
| irq | output | 1 | One-cycle interrupt pulse |
| fifo_rd | input | 1 | Removes the oldest capture |
| fifo_data | output | CNT_W | Oldest captured value |
| fifo_empty | output | 1 | Capture queue empty |
| fifo_full | output | 1 | Capture queue full |
| fifo_ovf | output | 1 | Sticky capture-drop flag |

## Verification
A wrong table entry or a stale previous-state register shows at the `count` port as a wrong step three edges after the offending input change. It also shows as a spurious or missing `err_flag`. A corrupted queue pointer shows on `fifo_data` at the next read as a value out of push order, or as `fifo_full` or `fifo_empty` disagreeing with the number of pushes and reads. A sequencer that arms too early applies a bogus transition from the reset state, and that step is visible on `count` within the first few cycles.

// File: rtl/tec_pkg.sv
package tec_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_INC  = 2'b01,
        ACT_DEC  = 2'b10,
        ACT_EXC  = 2'b11
    } tec_act_e;

    typedef struct packed {
        logic     irq;
        logic     cap;
        tec_act_e act;
    } tec_entry_t;

    typedef enum logic [1:0] {
        ST_SYNC0,
        ST_SYNC1,
        ST_SEED,
        ST_RUN
    } tec_state_e;
endpackage

// File: rtl/tec_sync.sv
module tec_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_a  <= '0;
            sync_out <= '0;
        end else begin
            stage_a  <= async_in;
            sync_out <= stage_a;
        end
    end
endmodule

// File: rtl/tec_table.sv
module tec_table
    import tec_pkg::*;
#(
    parameter int SW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2*SW-1:0] wr_addr,
    input  tec_entry_t      wr_entry,
    input  logic [2*SW-1:0] rd_addr,
    output tec_entry_t      rd_entry
);
    localparam int ENTRIES = 1 << (2 * SW);

    tec_entry_t mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '{irq: 1'b0, cap: 1'b0, act: ACT_HOLD};
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_entry;
        end
    end

    assign rd_entry = mem[rd_addr];
endmodule

// File: rtl/tec_fifo.sv
module tec_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          ovf_clr,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = PW + 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [OW-1:0] used;
    logic          do_pop, do_push;

    assign empty   = (used == '0);
    assign full    = (used == OW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                used <= used + 1'b1;
            end else if (do_pop && !do_push) begin
                used <= used - 1'b1;
            end
            if (push && !do_push) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trans_event_counter.sv
module trans_event_counter
    import tec_pkg::*;
#(
    parameter int NUM_IN     = 3,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   din,
    input  logic                tbl_we,
    input  logic [2*NUM_IN-1:0] tbl_addr,
    input  logic [3:0]          tbl_wdata,
    input  logic                flag_clr,
    output logic [CNT_W-1:0]    count,
    output logic                err_flag,
    output logic                irq,
    input  logic                fifo_rd,
    output logic [CNT_W-1:0]    fifo_data,
    output logic                fifo_empty,
    output logic                fifo_full,
    output logic                fifo_ovf
);
    tec_state_e        cur_st, nxt_st;
    logic [NUM_IN-1:0] cur_s, prev_s;
    tec_entry_t        entry;
    logic              in_run, st_same, step_ok;

    tec_sync #(.W(NUM_IN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(din), .sync_out(cur_s)
    );

    tec_table #(.SW(NUM_IN)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
        .wr_entry(tec_entry_t'(tbl_wdata)), .rd_addr({prev_s, cur_s}),
        .rd_entry(entry)
    );

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= ST_SYNC0;
        else        cur_st <= nxt_st;
    end

    // Sequencer: transitions and outputs
    always_comb begin
        nxt_st = cur_st;
        in_run = 1'b0;
        unique case (cur_st)
            ST_SYNC0: nxt_st = ST_SYNC1;   // T_FILL1
            ST_SYNC1: nxt_st = ST_SEED;    // T_FILL2
            ST_SEED:  nxt_st = ST_RUN;     // T_ARM
            ST_RUN: begin
                nxt_st = ST_RUN;           // T_STAY
                in_run = 1'b1;
            end
        endcase
    end

    assign st_same = (cur_s == prev_s);
    assign step_ok = in_run && !st_same;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_s   <= '0;
            count    <= '0;
            err_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            prev_s <= cur_s;
            irq    <= step_ok && entry.irq;
            if (step_ok) begin
                unique case (entry.act)
                    ACT_INC:  count <= count + 1'b1;
                    ACT_DEC:  count <= count - 1'b1;
                    ACT_HOLD: count <= count;
                    ACT_EXC:  count <= count;
                endcase
            end
            if (step_ok && entry.act == ACT_EXC) err_flag <= 1'b1;
            else if (flag_clr)                   err_flag <= 1'b0;
        end
    end

    tec_fifo #(.DW(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(step_ok && entry.cap),
        .push_data(count), .pop(fifo_rd), .ovf_clr(flag_clr),
        .head(fifo_data), .empty(fifo_empty), .full(fifo_full),
        .ovf(fifo_ovf)
    );
endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             err_flag,
    input logic             flag_clr,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             in_run,
    input logic             st_same
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + ONE) ||
        (count == $past(count) - ONE));

    assert_idle_until_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |=> $stable(count));

    assert_no_lookup_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && st_same |=> $stable(count));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !flag_clr |=> err_flag);

    assert_full_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
endmodule

bind trans_event_counter tec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .err_flag(err_flag),
    .flag_clr(flag_clr), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .in_run(in_run), .st_same(st_same)
);

// File: tb/trans_event_counter_bench.sv
`timescale 1ns/1ps
module trans_event_counter_bench;
    localparam int NI = 3;
    localparam int CW = 16;
    localparam int NV = 12;
    // {din[2:0], expected count[15:0]} under quadrature mapping on bits 1:0
    localparam logic [18:0] QVEC [NV] = '{
        {3'd1, 16'd1}, {3'd3, 16'd2}, {3'd3, 16'd2}, {3'd2, 16'd3},
        {3'd0, 16'd4}, {3'd2, 16'd3}, {3'd3, 16'd2}, {3'd1, 16'd1},
        {3'd0, 16'd0}, {3'd2, 16'hFFFF}, {3'd0, 16'd0}, {3'd1, 16'd1}
    };

    logic clk = 0, rst_n = 0;
    logic [NI-1:0] din = '0;
    logic tbl_we = 0, flag_clr = 0, fifo_rd = 0;
    logic [2*NI-1:0] tbl_addr = '0;
    logic [3:0] tbl_wdata = '0;
    logic [CW-1:0] count, fifo_data;
    logic err_flag, irq, fifo_empty, fifo_full, fifo_ovf;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    trans_event_counter u_trans_event_counter (
        .clk(clk), .rst_n(rst_n), .din(din), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .flag_clr(flag_clr),
        .count(count), .err_flag(err_flag), .irq(irq), .fifo_rd(fifo_rd),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_ovf(fifo_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_entry(input logic [2:0] p, input logic [2:0] c, input logic [3:0] d);
        @(negedge clk);
        tbl_we = 1; tbl_addr = {p, c}; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic step(input logic [2:0] v);
        @(negedge clk);
        din = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        check("R2 count", count, 0);
        check("R2 err", err_flag, 0);
        check("R2 irq", irq, 0);
        check("R2 empty", fifo_empty, 1);
        check("R2 full", fifo_full, 0);
        check("R2 ovf", fifo_ovf, 0);
        repeat (5) @(negedge clk);

        // R3: program quadrature (+1 / -1) and illegal double changes
        wr_entry(0, 1, 4'b0001); wr_entry(1, 3, 4'b0001);
        wr_entry(2, 0, 4'b0001); wr_entry(3, 2, 4'b0001);
        wr_entry(0, 2, 4'b0010); wr_entry(1, 0, 4'b0010);
        wr_entry(2, 3, 4'b0010); wr_entry(3, 1, 4'b0010);
        wr_entry(0, 3, 4'b0011); wr_entry(3, 0, 4'b0011);
        wr_entry(1, 2, 4'b0011); wr_entry(2, 1, 4'b0011);

        // R3 R4 R5: vector walk (hold, wrap below zero included)
        for (int i = 0; i < NV; i++) begin
            step(QVEC[i][18:16]);
            check("R4 quad walk", count, QVEC[i][15:0]);
            check("R5 no err", err_flag, 0);
        end
        step(3'd0);
        check("R4 back to zero", count, 0);

        // R6 exception
        step(3'd3);
        check("R6 err set", err_flag, 1);
        check("R6 count held", count, 0);
        @(negedge clk);
        check("R6 sticky", err_flag, 1);
        pulse_clr();
        check("R6 cleared", err_flag, 0);
        step(3'd2);
        check("R6 count after", count, 1);
        step(3'd0);
        check("R4 inc", count, 2);

        // R1 latency
        @(negedge clk); din = 3'd1;
        repeat (2) @(posedge clk); #1;
        check("R1 not yet", count, 2);
        @(posedge clk); #1;
        check("R1 third edge", count, 3);
        step(3'd0);
        check("R4 dec", count, 2);

        // R3 rewrite: 0->1 inc+capture+irq, 1->0 hold
        wr_entry(0, 1, 4'b1101);
        wr_entry(1, 0, 4'b0000);
        step(3'd1);
        check("R10 count", count, 3);
        check("R9 irq", irq, 1);
        check("R7 head", fifo_data, 2);
        check("R7 not empty", fifo_empty, 0);
        @(negedge clk);
        check("R9 one cycle", irq, 0);
        step(3'd0);
        check("R3 hold entry", count, 3);
        for (int k = 1; k < 9; k++) begin
            step(3'd1);
            step(3'd0);
        end
        check("R8 full", fifo_full, 1);
        check("R8 ovf", fifo_ovf, 1);
        check("R10 count after drops", count, 11);
        for (int k = 0; k < 8; k++) begin
            check("R7 order", fifo_data, 2 + k);
            @(negedge clk); fifo_rd = 1;
            @(negedge clk); fifo_rd = 0;
        end
        check("R7 empty", fifo_empty, 1);
        @(negedge clk); fifo_rd = 1;
        @(negedge clk); fifo_rd = 0;
        check("R7 empty read", fifo_empty, 1);
        check("R7 empty read full", fifo_full, 0);
        pulse_clr();
        check("R8 ovf cleared", fifo_ovf, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule